// File: doc/BRIEF.md
# Registered Two-Way Barrel Shifter

This block shifts a data word left or right by any amount from zero up to one less than the word width, within a single cycle of logic. A clock edge captures the data word, the shift amount, the direction select and the sign-mode select. The shifted result is then produced combinationally from those captured values. The result seen on the output therefore always belongs to the inputs presented before the most recent rising edge.

One datapath covers three operations:
- a left shift with zero fill;
- a logical right shift with zero fill;
- an arithmetic right shift that copies the sign bit into the vacated upper positions.

The datapath is a chain of logarithmic stages. Stage k moves the word by 2^k positions when bit k of the captured amount is set. The default build is 16 bits wide with a 4-bit amount.

Top module: `barrel_shift_reg`

## Requirements
- R1: While `rst_n` is low, the capture registers hold zero, so `dout` reads 0x0000 regardless of the other inputs. Reset is asynchronous.
- R2: `din`, `amt`, `dir_right` and `sign_mode` are captured only on the rising edge of `clk`. A change between edges does not alter `dout` until the next rising edge.
- R3: With `dir_right` = 0, `dout` is the captured word shifted left by the captured amount. The vacated low bits are zero, whatever the value of `sign_mode`.
- R4: With `dir_right` = 1 and `sign_mode` = 0, `dout` is the captured word shifted right by the captured amount, with zeros in the vacated high bits.
- R5: With `dir_right` = 1 and `sign_mode` = 1, `dout` is the captured word shifted right by the captured amount. Every vacated high bit equals bit 15 (the most significant bit) of the captured word.
- R6: A captured amount of 0 passes the captured word to `dout` unchanged in all four combinations of `dir_right` and `sign_mode`.
- R7: Every amount from 0 to 15 is honoured. At amount 15, a left shift leaves only bit 0 of the input, placed at bit 15. An arithmetic right shift at amount 15 yields 0xFFFF or 0x0000, following bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the capture registers |
| din | input | 16 | Data word to be shifted |
| amt | input | 4 | Shift distance, 0 to 15 |
| dir_right | input | 1 | 1 selects a right shift, 0 a left shift |
| sign_mode | input | 1 | 1 treats the word as signed (sign-extending right shift) |
| dout | output | 16 | Shifted form of the captured word |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a 4-bit amount. At that size, every combination of direction, sign mode and amount can be swept for each data pattern. The sweep crosses the four stage enables with the fill-bit choice, using single-bit, all-ones and sign-boundary words as well as seeded random words. The default width also brings the sign-bit fill at amount 15 within reach, along with the inter-edge stability of the output and the asynchronous reset.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;

  // Bit shifted into vacated high positions on a right move
  function automatic logic fill_bit(input shift_dir_e dir,
                                    input logic       signed_mode,
                                    input logic       msb);
    return (dir == DIR_RIGHT) && signed_mode && msb;
  endfunction

endpackage

// File: rtl/bsh_capture.sv
module bsh_capture
  import barrel_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          dir_right,
  input  logic          sign_mode,
  output logic [W-1:0]  q_data,
  output logic [AW-1:0] q_amt,
  output shift_dir_e    q_dir,
  output logic          q_sign
);

  logic [W-1:0]  n_data;
  logic [AW-1:0] n_amt;
  shift_dir_e    n_dir;
  logic          n_sign;

  always_comb begin
    n_data = din;
    n_amt  = amt;
    n_dir  = dir_right ? DIR_RIGHT : DIR_LEFT;
    n_sign = sign_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
      q_amt  <= '0;
      q_dir  <= DIR_LEFT;
      q_sign <= 1'b0;
    end else begin
      q_data <= n_data;
      q_amt  <= n_amt;
      q_dir  <= n_dir;
      q_sign <= n_sign;
    end
  end

  // R2: the captured word is the one present at the previous edge
  p_capture_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_data == $past(din)) && (q_amt == $past(amt)));

endmodule

// File: rtl/bsh_stage.sv
module bsh_stage
  import barrel_pkg::*;
#(
  parameter int W    = 16,
  parameter int DIST = 1
) (
  input  logic [W-1:0] in_word,
  input  logic         en,
  input  shift_dir_e   dir,
  input  logic         fill,
  output logic [W-1:0] out_word
);

  logic [W-1:0] moved;

  always_comb begin
    if (dir == DIR_RIGHT) moved = {{DIST{fill}}, in_word[W-1:DIST]};
    else                  moved = {in_word[W-1-DIST:0], {DIST{1'b0}}};
    out_word = en ? moved : in_word;
  end

endmodule

// File: rtl/barrel_shift_reg.sv
module barrel_shift_reg
  import barrel_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          dir_right,
  input  logic          sign_mode,
  output logic [W-1:0]  dout
);

  localparam int NST = AW;

  logic [W-1:0]  q_data;
  logic [AW-1:0] q_amt;
  shift_dir_e    q_dir;
  logic          q_sign;
  logic          fill;
  logic [NST:0][W-1:0] lane;

  bsh_capture #(.W(W), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .din(din), .amt(amt),
    .dir_right(dir_right), .sign_mode(sign_mode),
    .q_data(q_data), .q_amt(q_amt), .q_dir(q_dir), .q_sign(q_sign)
  );

  always_comb fill = fill_bit(q_dir, q_sign, q_data[W-1]);

  assign lane[0] = q_data;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    bsh_stage #(.W(W), .DIST(1 << k)) u_stg (
      .in_word(lane[k]), .en(q_amt[k]), .dir(q_dir),
      .fill(fill), .out_word(lane[k+1])
    );
  end

  assign dout = lane[NST];

  // R6: zero distance is a pass-through
  p_zero_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_amt == '0) |-> (dout == q_data));

  // R3: a left move always clears bit 0
  p_left_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_dir == DIR_LEFT && q_amt != '0) |-> (dout[0] == 1'b0));

  // R4: logical right move clears the top bit
  p_logic_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_dir == DIR_RIGHT && !q_sign && q_amt != '0) |-> (dout[W-1] == 1'b0));

  // R5: arithmetic right move keeps the sign bit
  p_arith_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_dir == DIR_RIGHT && q_sign) |-> (dout[W-1] == q_data[W-1]));

  // R3: a left move never creates set bits
  p_left_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_dir == DIR_LEFT) |-> ($countones(dout) <= $countones(q_data)));

endmodule

// File: tb/barrel_shift_reg_bench.sv
module barrel_shift_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] din;
  logic [3:0]  amt;
  logic        dir_right;
  logic        sign_mode;
  logic [15:0] dout;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  barrel_shift_reg u_barrel_shift_reg (
    .clk(clk), .rst_n(rst_n), .din(din), .amt(amt),
    .dir_right(dir_right), .sign_mode(sign_mode), .dout(dout)
  );

  function automatic logic [15:0] model(input logic [15:0] d, input int a,
                                        input logic r, input logic s);
    logic signed [15:0] t;
    t = d;
    if (!r)      return d << a;
    else if (s)  return 16'(t >>> a);
    else         return d >> a;
  endfunction

  function automatic string tag(input logic r, input logic s, input int a);
    if (a == 0)  return "R6";
    if (a == 15) return "R7";
    if (!r)      return "R3";
    if (!s)      return "R4";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at falling edge, capture at rising edge, sample at next falling edge
  task automatic apply(input logic [15:0] d, input int a, input logic r, input logic s);
    din = d; amt = 4'(a); dir_right = r; sign_mode = s;
    @(posedge clk);
    @(negedge clk);
    check(tag(r, s, a), dout, model(d, a, r, s));
  endtask

  task automatic sweep(input logic [15:0] d);
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 16; a++)
          apply(d, a, 1'(r), 1'(s));
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; din = 16'hA5A5; amt = 4'd3; dir_right = 1'b1; sign_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", dout, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner words through every mode and distance
    sweep(16'h8000);
    sweep(16'h7FFF);
    sweep(16'hFFFF);
    sweep(16'h0001);
    sweep(16'h0000);

    // R7 explicit extremes
    apply(16'h0001, 15, 1'b0, 1'b1);
    check("R7", dout, 16'h8000);
    apply(16'h8123, 15, 1'b1, 1'b1);
    check("R7", dout, 16'hFFFF);
    apply(16'h7123, 15, 1'b1, 1'b1);
    check("R7", dout, 16'h0000);

    // R3: sign_mode has no effect on a left move
    apply(16'hC003, 2, 1'b0, 1'b1);
    check("R3", dout, 16'h000C);

    // random words
    for (int i = 0; i < 24; i++) sweep(16'($urandom));
    for (int i = 0; i < 400; i++)
      apply(16'($urandom), int'($urandom % 16), 1'($urandom), 1'($urandom));

    // R2: changes between edges do not reach dout
    apply(16'h1234, 4, 1'b0, 1'b0);
    din = 16'hFFFF; amt = 4'd0; dir_right = 1'b1; sign_mode = 1'b1;
    #2;
    check("R2", dout, 16'h2340);
    @(posedge clk);
    @(negedge clk);
    check("R2", dout, 16'hFFFF);

    // R1: asynchronous reset mid-run
    apply(16'h8F00, 1, 1'b1, 1'b1);
    #1 rst_n = 1'b0;
    #1 check("R1", dout, 16'h0000);
    @(negedge clk);
    check("R1", dout, 16'h0000);
    rst_n = 1'b1;
    apply(16'h0F0F, 0, 1'b1, 1'b0);
    check("R6", dout, 16'h0F0F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule